// File: doc/BRIEF.md
# Control-Channel Serial Audio Word Extractor

This block sits on the receive side of a serialized video link. It runs on the pixel clock recovered by the deserializer and reads the control-bit word that the link carries during blanking. From four of those bits it rebuilds a serial audio stream in the usual two-channel inter-chip sound format: a data bit, a word-select line, a bit clock and an active-low select. It turns that stream back into 16-bit left and right samples. Each complete stereo pair goes to a downstream buffer with a one-cycle strobe.

Two qualification schemes are supported. A mode input picks between them. In pixel-rate mode, every pixel clock carries one bit, but only while the select bit is low, so the sender can stall the stream. In coded-stream mode, the sender toggles a slower bit clock inside the control word. Bits are taken on its rising edges, which are found by comparing it with its value one pixel clock earlier. The buffer cannot push back, so a pair that arrives while the buffer reports full is dropped and a sticky flag is raised.

Top module: `audx_extractor`

## Requirements
- R1: With mode_coded low, a bit is taken on every clock in which control bit 6 is low. The data bit is control bit 3 and the word select is control bit 4. Clocks with bit 6 high take nothing, and bit 5 has no effect in this mode.
- R2: With mode_coded high, a bit is taken only on a clock in which control bit 5 is high and was low in the previous clock. Bit 5 held high for several clocks yields one bit, and bit 6 has no effect. The history of bit 5 reads high just after reset.
- R3: A change of the word select between two consecutive accepted bits marks a word boundary. The bit that carries the change is the last bit of the previous word. The next accepted bit is the MSB of a new word, whose channel is the new word-select value (0 left, 1 right).
- R4: A word is assembled MSB first and completes on its 16th bit. Bits after the 16th and before the next boundary are ignored, and a word with fewer than 16 bits before a boundary is discarded.
- R5: When a right word completes after a completed left word, out_valid is high for exactly the clock after the completing bit, with out_left and out_right holding the pair. A right word with no completed left word before it produces no output.
- R6: If buf_full is high in the clock that completes a pair, that pair is dropped, out_valid stays low, and ovf_flag goes high and stays high until reset.
- R7: Synchronous reset clears out_valid, ovf_flag, the outputs and any partial word. After reset nothing is assembled until the first word-select change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_coded | input | 1 | 0: pixel-rate bits gated by select; 1: bits on bit-clock rising edges |
| ctl_word | input | 9 | Control-bit word from the deserializer |
| buf_full | input | 1 | Downstream buffer cannot accept a pair |
| out_valid | output | 1 | One-cycle strobe for a new stereo pair |
| out_left | output | 16 | Left sample of the last delivered pair |
| out_right | output | 16 | Right sample of the last delivered pair |
| ovf_flag | output | 1 | Sticky: a pair was dropped because the buffer was full |

## Verification
The least-bit capture and the word-boundary detection happen on the same accepted bit. The clock that shifts in the sixteenth bit of one word also resets the count for the next word and changes its channel. Every pair in the vector table ends this way, in both modes and with stall and hold cycles, so a boundary taken one bit early or late shows up as corrupted samples. Separate streams with a 20-bit word and a 10-bit word test the same coincidence when the count is not at its last bit: the long word must be truncated and the short word must suppress the pair.

// File: rtl/audx_pkg.sv
package audx_pkg;

    localparam int CTRL_W   = 9;
    localparam int SAMPLE_W = 16;

    // Positions inside the control word that the sender drives.
    localparam int POS_SD   = 3;
    localparam int POS_WS   = 4;
    localparam int POS_BCLK = 5;
    localparam int POS_SELN = 6;

    typedef enum logic {
        MODE_PIXEL = 1'b0,
        MODE_CODED = 1'b1
    } link_mode_e;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    typedef struct packed {
        logic sd;
        logic ws;
        logic bclk;
        logic sel_n;
    } ctl_tap_t;

    typedef struct packed {
        logic  done;
        chan_e ch;
    } word_evt_t;

    function automatic ctl_tap_t tap_ctl(input logic [CTRL_W-1:0] w);
        ctl_tap_t t;
        t.sd    = w[POS_SD];
        t.ws    = w[POS_WS];
        t.bclk  = w[POS_BCLK];
        t.sel_n = w[POS_SELN];
        return t;
    endfunction

endpackage

// File: rtl/audx_bit_strobe.sv
module audx_bit_strobe
    import audx_pkg::*;
#(
    parameter int CW = audx_pkg::CTRL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  link_mode_e    mode,
    input  logic [CW-1:0] ctl_word,
    output logic          bit_stb,
    output logic          bit_sd,
    output logic          bit_ws
);

    ctl_tap_t tap;
    logic     bclk_q;

    assign tap    = tap_ctl(ctl_word);
    assign bit_sd = tap.sd;
    assign bit_ws = tap.ws;

    // History of the bit clock; reads high after reset so a clock
    // already high is not taken as an edge.
    always_ff @(posedge clk) begin
        if (rst) bclk_q <= 1'b1;
        else     bclk_q <= tap.bclk;
    end

    always_comb begin
        unique case (mode)
            MODE_PIXEL: bit_stb = !tap.sel_n;
            MODE_CODED: bit_stb = tap.bclk && !bclk_q;
            default:    bit_stb = 1'b0;
        endcase
    end

    // R2: two coded-mode bits can never be taken in adjacent clocks
    p_coded_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CODED && bit_stb) |=> !(bit_stb && mode == MODE_CODED));

endmodule

// File: rtl/audx_word_asm.sv
module audx_word_asm
    import audx_pkg::*;
#(
    parameter int WW = audx_pkg::SAMPLE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_stb,
    input  logic          bit_sd,
    input  logic          bit_ws,
    output word_evt_t     evt,
    output logic [WW-1:0] word_data
);

    localparam int CNT_W = $clog2(WW + 1);
    localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(WW);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WW - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic          ws_seen;
    logic          ws_prev;
    chan_e         cur_ch;
    logic [CNT_W-1:0] cnt;
    logic [WW-1:0] shreg;
    logic          filling;
    logic          boundary;
    logic [WW-1:0] next_shreg;

    assign filling    = cnt < CNT_IDLE;
    assign boundary   = ws_seen && (bit_ws != ws_prev);
    assign next_shreg = {shreg[WW-2:0], bit_sd};

    // Completion is presented in the same clock as its last bit.
    assign evt.done  = bit_stb && ws_seen && filling && (cnt == CNT_LAST);
    assign evt.ch    = cur_ch;
    assign word_data = next_shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            ws_seen <= 1'b0;
            ws_prev <= 1'b0;
            cur_ch  <= CH_LEFT;
            cnt     <= CNT_IDLE;
            shreg   <= '0;
        end else if (bit_stb) begin
            if (!ws_seen) begin
                ws_seen <= 1'b1;
                ws_prev <= bit_ws;
            end else begin
                if (filling) begin
                    shreg <= next_shreg;
                    cnt   <= cnt + CNT_ONE;
                end
                if (boundary) begin
                    ws_prev <= bit_ws;
                    cur_ch  <= chan_e'(bit_ws);
                    cnt     <= '0;
                end
            end
        end
    end

    // R4: a word needs a full set of bits, so completions never touch
    p_done_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        evt.done |=> !evt.done);

endmodule

// File: rtl/audx_pair_out.sv
module audx_pair_out
    import audx_pkg::*;
#(
    parameter int WW = audx_pkg::SAMPLE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  word_evt_t     evt,
    input  logic [WW-1:0] word_data,
    input  logic          buf_full,
    output logic          out_valid,
    output logic [WW-1:0] out_left,
    output logic [WW-1:0] out_right,
    output logic          ovf_flag
);

    logic [WW-1:0] left_hold;
    logic          left_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_hold <= '0;
            left_ok   <= 1'b0;
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
            ovf_flag  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (evt.done) begin
                if (evt.ch == CH_LEFT) begin
                    left_hold <= word_data;
                    left_ok   <= 1'b1;
                end else begin
                    left_ok <= 1'b0;
                    if (left_ok) begin
                        if (buf_full) begin
                            ovf_flag <= 1'b1;
                        end else begin
                            out_valid <= 1'b1;
                            out_left  <= left_hold;
                            out_right <= word_data;
                        end
                    end
                end
            end
        end
    end

    // R5: the pair strobe lasts a single clock
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R6: overflow is sticky
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    // R6: overflow only rises after a completion seen with a full buffer
    p_ovf_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> ($past(buf_full) && $past(evt.done)));

    // R6: a completion against a full buffer never strobes
    p_no_valid_full_r6: assert property (@(posedge clk) disable iff (rst)
        (evt.done && buf_full) |=> !out_valid);

endmodule

// File: rtl/audx_extractor.sv
module audx_extractor
    import audx_pkg::*;
#(
    parameter int CW = audx_pkg::CTRL_W,
    parameter int WW = audx_pkg::SAMPLE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_coded,
    input  logic [CW-1:0] ctl_word,
    input  logic          buf_full,
    output logic          out_valid,
    output logic [WW-1:0] out_left,
    output logic [WW-1:0] out_right,
    output logic          ovf_flag
);

    link_mode_e    mode;
    logic          bit_stb;
    logic          bit_sd;
    logic          bit_ws;
    word_evt_t     evt;
    logic [WW-1:0] word_data;

    assign mode = link_mode_e'(mode_coded);

    audx_bit_strobe #(.CW(CW)) u_stb (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .ctl_word (ctl_word),
        .bit_stb  (bit_stb),
        .bit_sd   (bit_sd),
        .bit_ws   (bit_ws)
    );

    audx_word_asm #(.WW(WW)) u_asm (
        .clk       (clk),
        .rst       (rst),
        .bit_stb   (bit_stb),
        .bit_sd    (bit_sd),
        .bit_ws    (bit_ws),
        .evt       (evt),
        .word_data (word_data)
    );

    audx_pair_out #(.WW(WW)) u_out (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .word_data (word_data),
        .buf_full  (buf_full),
        .out_valid (out_valid),
        .out_left  (out_left),
        .out_right (out_right),
        .ovf_flag  (ovf_flag)
    );

endmodule

// File: tb/audx_extractor_tb_top.sv
`timescale 1ns/1ps
module audx_extractor_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_coded = 1'b0;
    logic [8:0]  ctl_word = 9'h0;
    logic        buf_full = 1'b0;
    logic        out_valid;
    logic [15:0] out_left;
    logic [15:0] out_right;
    logic        ovf_flag;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    audx_extractor dut_i (
        .clk        (clk),
        .rst        (rst),
        .mode_coded (mode_coded),
        .ctl_word   (ctl_word),
        .buf_full   (buf_full),
        .out_valid  (out_valid),
        .out_left   (out_left),
        .out_right  (out_right),
        .ovf_flag   (ovf_flag)
    );

    typedef struct packed {
        logic        coded;
        logic [1:0]  gap;
        logic [1:0]  hold;
        logic [15:0] l;
        logic [15:0] r;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{coded:1'b0, gap:2'd0, hold:2'd0, l:16'hA5C3, r:16'h5A3C},
        '{coded:1'b0, gap:2'd2, hold:2'd0, l:16'h8001, r:16'h7FFE},
        '{coded:1'b1, gap:2'd0, hold:2'd0, l:16'h1234, r:16'hFEDC},
        '{coded:1'b1, gap:2'd1, hold:2'd2, l:16'hFFFF, r:16'h0000},
        '{coded:1'b0, gap:2'd1, hold:2'd0, l:16'h0000, r:16'hFFFF},
        '{coded:1'b1, gap:2'd3, hold:2'd1, l:16'hC0DE, r:16'hBEEF}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bit 3 data, bit 4 word select, bit 5 bit clock, bit 6 active-low select;
    // unrelated bits carry junk.
    function automatic logic [8:0] mk(input logic sd, input logic ws,
                                      input logic bclk, input logic seln);
        logic [8:0] w;
        w = 9'b110000101;
        w[3] = sd;
        w[4] = ws;
        w[5] = bclk;
        w[6] = seln;
        return w;
    endfunction

    // The accepted clock is always the last one of the call, except for
    // coded-mode hold cycles after it.
    task automatic send_bit(input logic coded, input logic sd, input logic ws,
                            input int gap, input int hold);
        mode_coded = coded;
        if (!coded) begin
            for (int g = 0; g < gap; g++) begin
                ctl_word = mk(~sd, ~ws, g[0], 1'b1);
                tick();
            end
            ctl_word = mk(sd, ws, 1'b0, 1'b0);
            tick();
        end else begin
            for (int g = 0; g < gap + 1; g++) begin
                ctl_word = mk(~sd, ~ws, 1'b0, 1'b0);
                tick();
            end
            ctl_word = mk(sd, ws, 1'b1, 1'b1);
            tick();
            for (int h = 0; h < hold; h++) begin
                ctl_word = mk(~sd, ~ws, 1'b1, 1'b0);
                tick();
            end
        end
    endtask

    task automatic send_pair(input logic coded, input int gap, input int hold,
                             input logic [15:0] l, input logic [15:0] r);
        for (int i = 15; i >= 1; i--) send_bit(coded, l[i], 1'b0, gap, hold);
        send_bit(coded, l[0], 1'b1, gap, hold);
        for (int i = 15; i >= 1; i--) send_bit(coded, r[i], 1'b1, gap, hold);
        send_bit(coded, r[0], 1'b0, gap, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        ctl_word = mk(1'b0, 1'b0, 1'b0, 1'b1);
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R7: reset state
        check("R7 valid after reset", 32'(out_valid), 32'd0);
        check("R7 ovf after reset", 32'(ovf_flag), 32'd0);
        check("R7 left after reset", 32'(out_left), 32'd0);

        // Preamble: seed word select, then a change that opens the first left word
        send_bit(1'b0, 1'b0, 1'b1, 0, 0);
        send_bit(1'b0, 1'b0, 1'b0, 0, 0);

        // R1 R2 R3 R4 R5: table of pairs in both modes, with stalls and holds
        for (int v = 0; v < NV; v++) begin
            send_pair(VECS[v].coded, int'(VECS[v].gap), int'(VECS[v].hold),
                      VECS[v].l, VECS[v].r);
            check(VECS[v].coded ? "R2 R5 valid strobe" : "R1 R5 valid strobe",
                  32'(out_valid), 32'd1);
            check("R3 R4 left word", 32'(out_left), 32'(VECS[v].l));
            check("R3 R4 right word", 32'(out_right), 32'(VECS[v].r));
            ctl_word = mk(1'b1, 1'b1, 1'b0, 1'b1);
            tick();
            check("R5 strobe one clock", 32'(out_valid), 32'd0);
        end

        // R6: pair completing against a full buffer
        buf_full = 1'b1;
        send_pair(1'b0, 0, 0, 16'h1111, 16'h2222);
        check("R6 dropped pair no valid", 32'(out_valid), 32'd0);
        check("R6 ovf raised", 32'(ovf_flag), 32'd1);
        check("R6 outputs kept", 32'(out_left), 32'(VECS[NV-1].l));
        buf_full = 1'b0;
        send_pair(1'b0, 0, 0, 16'h3333, 16'h4444);
        check("R6 next pair delivered", 32'(out_valid), 32'd1);
        check("R6 next pair left", 32'(out_left), 32'h3333);
        check("R6 ovf sticky", 32'(ovf_flag), 32'd1);

        // R4: 20-bit left word truncated to its first 16 bits
        for (int i = 15; i >= 0; i--) send_bit(1'b0, 16'h9C5A >> i, 1'b0, 0, 0);
        send_bit(1'b0, 1'b1, 1'b0, 0, 0);
        send_bit(1'b0, 1'b1, 1'b0, 0, 0);
        send_bit(1'b0, 1'b0, 1'b0, 0, 0);
        send_bit(1'b0, 1'b1, 1'b1, 0, 0);
        for (int i = 15; i >= 1; i--) send_bit(1'b0, 16'h0F0F >> i, 1'b1, 0, 0);
        send_bit(1'b0, 1'b1, 1'b0, 0, 0);
        check("R4 long word valid", 32'(out_valid), 32'd1);
        check("R4 long word truncated", 32'(out_left), 32'h9C5A);
        check("R4 right after long", 32'(out_right), 32'h0F0F);

        // R4: 10-bit left word discarded, so no pair follows
        for (int i = 0; i < 9; i++) send_bit(1'b0, 1'b1, 1'b0, 0, 0);
        send_bit(1'b0, 1'b1, 1'b1, 0, 0);
        for (int i = 15; i >= 1; i--) send_bit(1'b0, 1'b0, 1'b1, 0, 0);
        send_bit(1'b0, 1'b0, 1'b0, 0, 0);
        check("R4 short word suppresses pair", 32'(out_valid), 32'd0);
        check("R4 outputs unchanged", 32'(out_left), 32'h9C5A);

        // R7: reset mid-word, then no assembly until a select change
        for (int i = 0; i < 8; i++) send_bit(1'b0, 1'b1, 1'b0, 0, 0);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        ctl_word = mk(1'b0, 1'b0, 1'b0, 1'b1);
        tick();
        check("R7 ovf cleared", 32'(ovf_flag), 32'd0);
        check("R7 outputs cleared", 32'(out_right), 32'd0);
        send_pair(1'b0, 0, 0, 16'h5555, 16'h6666);
        check("R7 no pair before first select change", 32'(out_valid), 32'd0);
        send_pair(1'b0, 0, 0, 16'h7777, 16'h8888);
        check("R7 pair after resync", 32'(out_valid), 32'd1);
        check("R7 left after resync", 32'(out_left), 32'h7777);

        finish_run();
    end

endmodule